// File: doc/BRIEF.md
# Funnel Shifter with Mode Select

A purely combinational shifter for a W-bit datapath (W = 32 by default). It forms a 2W-bit value from an upper word and a lower word. It then returns the low W bits of that value after shifting it right by an offset. One window extractor handles every shift kind. Each mode chooses the upper word, the lower word and the offset.

For a logical right shift, the upper word is zero and the lower word is the operand. For an arithmetic right shift, the upper word is filled with the operand's sign bit. For a rotate, both words are the operand and the offset is taken modulo W. For a left shift, the upper word is the operand, the lower word is zero and the offset is W minus the requested amount.

The extractor is a cascade of 2:1 multiplexer levels. Level k shifts by 2^k positions when bit k of the offset is set.

Top module: `funnel_shift_unit`

## Requirements
- R1: With mode_in = 2'b00 (logical right), res_out equals a_in shifted right by the effective amount, with zeros filling the vacated upper bits.
- R2: With mode_in = 2'b01 (arithmetic right), res_out equals a_in shifted right by the effective amount, with copies of a_in[W-1] filling the vacated upper bits.
- R3: With mode_in = 2'b10 (rotate right), bit j of res_out equals a_in[(j + n) mod W], where n is the effective amount.
- R4: With mode_in = 2'b11 (logical left), res_out equals a_in shifted left by the effective amount, with zeros filling the vacated lower bits.
- R5: An amount of 0 returns a_in unchanged in every mode.
- R6: An effective amount of W gives the following results:
  - logical right and logical left give all zeros;
  - arithmetic right gives W copies of a_in[W-1];
  - rotate right returns a_in.
- R7: amt_in values above W (33 to 63 at the default width) behave exactly as an amount of W.
- R8: The block holds no state. res_out depends only on the present a_in, amt_in and mode_in. It changes in the same cycle as they do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | Operand to shift |
| amt_in | input | $clog2(W)+1 | Requested shift amount; values above W saturate to W |
| mode_in | input | 2 | 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| res_out | output | W | Shifted result |

## Verification
A fixed table of operands is applied in all four modes, and each result is compared with a bit-by-bit model kept in the bench.

The table includes operands with the top bit set and with it clear. These separate arithmetic fill from logical fill, and rotate wrap-around from zero fill.

A full sweep of amounts from 0 to 63 runs in every mode on an asymmetric operand. The sweep exposes a fault in any single multiplexer level, in the offset arithmetic of the left mode, and in the saturation of oversize amounts.

Directed cases at amounts 0, W and above W pin down the boundary results. A change of inputs with no clock edge between them shows that no state is held.

// File: rtl/funnel_shift_pkg.sv
package funnel_shift_pkg;

  typedef enum logic [1:0] {
    SHM_LRIGHT = 2'b00,
    SHM_ARIGHT = 2'b01,
    SHM_ROTR   = 2'b10,
    SHM_LLEFT  = 2'b11
  } shift_mode_e;

  // True for the modes that move bits toward the least significant end
  function automatic logic mode_is_right(input shift_mode_e m);
    return (m != SHM_LLEFT);
  endfunction

endpackage

// File: rtl/funnel_operand_sel.sv
// Picks the upper word, lower word and window offset for each mode.
module funnel_operand_sel
  import funnel_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  shift_mode_e   mode,
  output logic [W-1:0]  hi_word,
  output logic [W-1:0]  lo_word,
  output logic [AW-1:0] offset,
  output logic [AW-1:0] amt_eff
);

  localparam logic [AW-1:0] FULL = AW'(W);

  // Amounts beyond the word width act as a full-width shift
  function automatic logic [AW-1:0] saturate_amt(input logic [AW-1:0] x);
    return (x > FULL) ? FULL : x;
  endfunction

  // Rotation offset modulo W (W is a power of two)
  function automatic logic [AW-1:0] wrap_amt(input logic [AW-1:0] x);
    return {1'b0, x[AW-2:0]};
  endfunction

  // Left shift by n is a right window at W - n over {A, 0}
  function automatic logic [AW-1:0] left_offset(input logic [AW-1:0] x);
    return FULL - x;
  endfunction

  assign amt_eff = saturate_amt(amt);

  always_comb begin
    hi_word = '0;
    lo_word = a;
    offset  = amt_eff;
    unique case (mode)
      SHM_LRIGHT: begin
        hi_word = '0;
        lo_word = a;
        offset  = amt_eff;
      end
      SHM_ARIGHT: begin
        hi_word = {W{a[W-1]}};
        lo_word = a;
        offset  = amt_eff;
      end
      SHM_ROTR: begin
        hi_word = a;
        lo_word = a;
        offset  = wrap_amt(amt_eff);
      end
      SHM_LLEFT: begin
        hi_word = a;
        lo_word = '0;
        offset  = left_offset(amt_eff);
      end
      default: begin
        hi_word = '0;
        lo_word = a;
        offset  = amt_eff;
      end
    endcase
  end

endmodule

// File: rtl/funnel_window.sv
// Right-shifts a 2W-bit concatenation through log2 levels of 2:1 muxes
// and returns the low W bits.
module funnel_window #(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  hi_word,
  input  logic [W-1:0]  lo_word,
  input  logic [AW-1:0] offset,
  output logic [W-1:0]  window
);

  localparam int DW = 2 * W;

  logic [DW-1:0] level [0:AW];

  assign level[0] = {hi_word, lo_word};

  generate
    for (genvar k = 0; k < AW; k++) begin : g_level
      localparam int STEP = 1 << k;
      assign level[k+1] = offset[k] ? (level[k] >> STEP) : level[k];
    end
  endgenerate

  assign window = level[AW][W-1:0];

endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
  import funnel_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  a_in,
  input  logic [AW-1:0] amt_in,
  input  logic [1:0]    mode_in,
  output logic [W-1:0]  res_out
);

  shift_mode_e   mode_q;
  logic [W-1:0]  sel_hi;
  logic [W-1:0]  sel_lo;
  logic [AW-1:0] sel_offset;
  logic [AW-1:0] sel_amt_eff;
  logic          sel_is_right;

  assign mode_q       = shift_mode_e'(mode_in);
  assign sel_is_right = mode_is_right(mode_q);

  funnel_operand_sel #(.W(W), .AW(AW)) u_sel (
    .a       (a_in),
    .amt     (amt_in),
    .mode    (mode_q),
    .hi_word (sel_hi),
    .lo_word (sel_lo),
    .offset  (sel_offset),
    .amt_eff (sel_amt_eff)
  );

  funnel_window #(.W(W), .AW(AW)) u_win (
    .hi_word (sel_hi),
    .lo_word (sel_lo),
    .offset  (sel_offset),
    .window  (res_out)
  );

endmodule

// File: rtl/funnel_shift_chk.sv
module funnel_shift_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input logic [W-1:0]  a_in,
  input logic [AW-1:0] amt_in,
  input logic [1:0]    mode_in,
  input logic [W-1:0]  res_out,
  input logic [AW-1:0] sel_offset,
  input logic [AW-1:0] sel_amt_eff,
  input logic          sel_is_right
);

  logic [AW-1:0] n;
  assign n = (amt_in > AW'(W)) ? AW'(W) : amt_in;

  always_comb begin
    if (mode_in == 2'b00)
      a_r1_lright: assert (res_out == (a_in >> n)) else $error("R1 logical right");
    if (mode_in == 2'b01)
      a_r2_aright: assert (res_out == W'($signed(a_in) >>> n)) else $error("R2 arithmetic right");
    if (mode_in == 2'b10)
      a_r3_rot_pop: assert ($countones(res_out) == $countones(a_in)) else $error("R3 rotate bit count");
    if (mode_in == 2'b11)
      a_r4_lleft: assert (res_out == (a_in << n)) else $error("R4 logical left");
    if (amt_in == '0)
      a_r5_zero_amt: assert (res_out == a_in) else $error("R5 zero amount");
    if (amt_in >= AW'(W) && mode_in == 2'b10)
      a_r6_rot_full: assert (res_out == a_in) else $error("R6 rotate by W");
    a_r7_sat: assert (sel_amt_eff <= AW'(W) && sel_offset <= AW'(W)) else $error("R7 saturation");
    if (mode_in == 2'b11)
      a_r4_dir: assert (!sel_is_right) else $error("R4 direction flag");
  end

endmodule

bind funnel_shift_unit funnel_shift_chk #(.W(W), .AW(AW)) u_chk (
  .a_in        (a_in),
  .amt_in      (amt_in),
  .mode_in     (mode_in),
  .res_out     (res_out),
  .sel_offset  (sel_offset),
  .sel_amt_eff (sel_amt_eff),
  .sel_is_right(sel_is_right)
);

// File: tb/funnel_shift_unit_tb.sv
module funnel_shift_unit_tb;

  localparam int W          = 32;
  localparam int AW         = 6;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  // Each entry: {amount[5:0], operand[31:0]}, applied in all four modes
  localparam logic [37:0] VEC [0:NVEC-1] = '{
    {6'd0,  32'h1234_5678},
    {6'd1,  32'h8000_0001},
    {6'd4,  32'hF0F0_0F0F},
    {6'd7,  32'h0000_00FF},
    {6'd8,  32'h8765_4321},
    {6'd13, 32'hDEAD_BEEF},
    {6'd16, 32'h7FFF_0000},
    {6'd21, 32'hC000_0003},
    {6'd31, 32'h8000_0000},
    {6'd31, 32'h0000_0001},
    {6'd32, 32'hA5A5_5A5A},
    {6'd47, 32'h9ABC_DEF0}
  };

  logic          clk = 1'b0;
  logic [W-1:0]  a_in;
  logic [AW-1:0] amt_in;
  logic [1:0]    mode_in;
  logic [W-1:0]  res_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  funnel_shift_unit #(.W(W)) u_dut (
    .a_in    (a_in),
    .amt_in  (amt_in),
    .mode_in (mode_in),
    .res_out (res_out)
  );

  // Bit-by-bit reference: each result bit names the operand bit it comes from
  function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                         input int amt, input logic [1:0] m);
    logic [W-1:0] r;
    int n;
    n = (amt > W) ? W : amt;
    for (int j = 0; j < W; j++) begin
      case (m)
        2'b00: r[j] = (j + n < W) ? a[j + n] : 1'b0;
        2'b01: r[j] = (j + n < W) ? a[j + n] : a[W-1];
        2'b10: r[j] = a[(j + n) % W];
        default: r[j] = (j - n >= 0) ? a[j - n] : 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (res_out !== exp) begin
      n_fails++;
      $display("FAIL %s: a=%h amt=%0d mode=%b got %h expected %h",
               req, a_in, amt_in, mode_in, res_out, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input int amt, input logic [1:0] m);
    @(negedge clk);
    a_in = a; amt_in = AW'(amt); mode_in = m;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    a_in = '0; amt_in = '0; mode_in = 2'b00;
    // Start-up state: zero operand gives zero result
    apply('0, 0, 2'b00);
    check("R5", '0);

    // Table walk, every vector in every mode (R1 R2 R3 R4)
    for (int v = 0; v < NVEC; v++) begin
      for (int m = 0; m < 4; m++) begin
        apply(VEC[v][31:0], int'(VEC[v][37:32]), 2'(m));
        check(req_of(2'(m)), model(VEC[v][31:0], int'(VEC[v][37:32]), 2'(m)));
      end
    end

    // Full amount sweep on an asymmetric operand, includes R7 range
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 64; k++) begin
        apply(32'h8F00_00F1, k, 2'(m));
        check((k > W) ? "R7" : req_of(2'(m)), model(32'h8F00_00F1, k, 2'(m)));
      end
    end

    // R5: amount 0 in every mode
    for (int m = 0; m < 4; m++) begin
      apply(32'hC3A5_0F96, 0, 2'(m));
      check("R5", 32'hC3A5_0F96);
    end

    // R6: full-width amount
    apply(32'h8123_4567, 32, 2'b00); check("R6", 32'h0000_0000);
    apply(32'h8123_4567, 32, 2'b01); check("R6", 32'hFFFF_FFFF);
    apply(32'h4123_4567, 32, 2'b01); check("R6", 32'h0000_0000);
    apply(32'h8123_4567, 32, 2'b10); check("R6", 32'h8123_4567);
    apply(32'h8123_4567, 32, 2'b11); check("R6", 32'h0000_0000);

    // R7: oversize amounts equal amount W
    apply(32'h8123_4567, 63, 2'b01); check("R7", 32'hFFFF_FFFF);
    apply(32'h8123_4567, 33, 2'b10); check("R7", 32'h8123_4567);
    apply(32'h8123_4567, 40, 2'b11); check("R7", 32'h0000_0000);

    // R8: two input changes inside one low phase, no clock edge between
    @(negedge clk);
    a_in = 32'h0000_F000; amt_in = 6'd4; mode_in = 2'b11;
    #1 check("R8", 32'h000F_0000);
    a_in = 32'h8000_0000; amt_in = 6'd1; mode_in = 2'b01;
    #1 check("R8", 32'hC000_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule